// File: doc/BRIEF.md
# Extension interface handle dispatcher

This block sits on the CPU side of a generic extension mechanism. Eight fixed control instructions, plus an open and a close instruction, are redirected to different hardware devices through a per-process handle. A set of interfaces is fixed at build time. Each interface has a 20-bit identifier, a mask of the control functions it implements, and a flag that says whether it takes a shutdown request. Opening an interface allocates a handle. The handle records which interface was opened and which address space opened it.

Each request carries an operation, a control function number, the low bits of the rs1 operand and the requester's address-space ID. The dispatcher checks the handle, the owner and the function. It then either answers at once with a result code or forwards the request to the device port with a routing index. It accepts one request at a time and stays busy until the device responds. The low 12 bits of rs1 are extra information that goes to the device unchanged. The handle sits in rs1 bits 15:12.

Top module: `xif_dispatch`

## Requirements
- R1: An open (req_op=0) whose identifier (req_arg[19:0]) matches a built-in interface returns code 0 with done_value equal to the lowest free handle index. Handle 0 is never issued. The result shows on done_valid in the cycle after acceptance.
- R2: An open of an unknown identifier returns code 1 (no such interface) with value 0 and allocates nothing. This check has priority over the full check.
- R3: With every handle from 1 to 15 in use, an open of a known identifier returns code 3 (out of handles) with value 0.
- R4: A control request (req_op=2) on an open handle from the owning address space, for a function set in the interface's mask, is forwarded. The device port carries dev_shutdown=0, the interface index, the function, the handle and rs1[11:0]. The device status comes back with code 0.
- R5: A control request on a free handle, or from a different address space, returns code 1 with value 0 and sends nothing to the device.
- R6: A control request for a function the interface does not implement returns code 2 (no such instruction) with value 0 and sends nothing to the device.
- R7: A close (req_op=1) on a free handle, or from a different address space, returns code 4 with value 32'hFFFFFFFF and sends nothing to the device.
- R8: A close on an interface that takes a shutdown request is forwarded with dev_shutdown=1. A nonzero device status returns code 4 with that status, and the handle stays open. A zero status returns code 0 with value 0 and frees the handle.
- R9: A close on an interface without a shutdown request frees the handle at once and returns code 0 with value 0. Nothing is sent to the device.
- R10: From the acceptance of a forwarded request until its response, req_ready is low and dev_valid is held with stable fields until dev_ready. With a device that accepts in the next cycle and responds one cycle later, the result is due three cycles after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Dispatcher idle, request taken this cycle |
| req_op | input | 2 | 0 open, 1 close, 2 control |
| req_fn | input | 3 | Control function number 0..7 |
| req_arg | input | 20 | Low rs1 bits: identifier on open; handle [15:12] and extra info [11:0] otherwise |
| req_asid | input | 8 | Address-space ID of the requester |
| dev_valid | output | 1 | Forwarded request to device |
| dev_ready | input | 1 | Device takes the request |
| dev_shutdown | output | 1 | 1 shutdown request, 0 control request |
| dev_if | output | 2 | Routing index of the interface |
| dev_fn | output | 3 | Control function number |
| dev_handle | output | 4 | Handle index |
| dev_aux | output | 12 | rs1[11:0] passed through unchanged |
| dev_rsp_valid | input | 1 | Device response present |
| dev_rsp_status | input | 32 | Device status word |
| done_valid | output | 1 | One-cycle result pulse |
| done_code | output | 3 | 0 ok, 1 no interface, 2 no instruction, 3 out of handles, 4 close failed |
| done_value | output | 32 | Handle, device status, -1 or 0 |

## Verification
A request decided locally gives its result one clock after acceptance. A forwarded request gives its result three clocks after acceptance with the bench device, which raises ready at the first falling edge after acceptance and responds one cycle later. The bench drives and samples on falling edges. It counts falling edges from acceptance to done_valid and compares the count with 1 or 3, depending on whether a device request was expected. It also checks that req_ready is already low at the first falling edge of a forwarded request. Device fields are captured at the falling edge where the bench raises ready, while dev_valid holds them stable.

// File: rtl/xif_pkg.sv
package xif_pkg;

  typedef enum logic [1:0] {
    OP_OPEN  = 2'd0,
    OP_CLOSE = 2'd1,
    OP_CTL   = 2'd2
  } xif_op_e;

  typedef enum logic [2:0] {
    RES_OK        = 3'd0,
    RES_NOIF      = 3'd1,
    RES_NOINSN    = 3'd2,
    RES_FULL      = 3'd3,
    RES_CLOSE_ERR = 3'd4
  } xif_res_e;

  // Lowest unused slot among 1..n-1; 0 means none (slot 0 is reserved).
  function automatic int unsigned lowest_free(input logic [63:0] used, input int unsigned n);
    int unsigned r;
    r = 0;
    for (int i = 63; i >= 1; i--) begin
      if (i < n && !used[i]) r = i;
    end
    return r;
  endfunction

endpackage

// File: rtl/xif_iface_map.sv
module xif_iface_map #(
  parameter int NUM_IF = 3,
  parameter int ID_W   = 20,
  parameter int NCTL   = 8,
  parameter int IFW    = 2,
  parameter logic [NUM_IF*ID_W-1:0] IF_IDS      = '0,
  parameter logic [NUM_IF*NCTL-1:0] IF_FN_MASK  = '0,
  parameter logic [NUM_IF-1:0]      IF_SHUTDOWN = '0
) (
  input  logic [ID_W-1:0] id_q,
  output logic            id_hit,
  output logic [IFW-1:0]  id_idx,
  input  logic [IFW-1:0]  sel,
  output logic [NCTL-1:0] sel_mask,
  output logic            sel_shut
);

  logic [NUM_IF-1:0] hits;

  genvar g;
  generate
    for (g = 0; g < NUM_IF; g++) begin : g_cmp
      assign hits[g] = (IF_IDS[g*ID_W +: ID_W] == id_q);
    end
  endgenerate

  assign id_hit = |hits;

  always_comb begin
    id_idx = '0;
    for (int i = NUM_IF - 1; i >= 0; i--) begin
      if (hits[i]) id_idx = IFW'(i);
    end
  end

  always_comb begin
    sel_mask = '0;
    sel_shut = 1'b0;
    for (int i = 0; i < NUM_IF; i++) begin
      if (sel == IFW'(i)) begin
        sel_mask = IF_FN_MASK[i*NCTL +: NCTL];
        sel_shut = IF_SHUTDOWN[i];
      end
    end
  end

endmodule

// File: rtl/xif_handle_tbl.sv
module xif_handle_tbl #(
  parameter int NUM_HANDLES = 16,
  parameter int IFW         = 2,
  parameter int ASID_W      = 8,
  parameter int HW          = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HW-1:0]     rd_idx,
  output logic              rd_valid,
  output logic [IFW-1:0]    rd_if,
  output logic [ASID_W-1:0] rd_asid,
  input  logic              alloc_en,
  input  logic [IFW-1:0]    alloc_if,
  input  logic [ASID_W-1:0] alloc_asid,
  output logic [HW-1:0]     alloc_idx,
  output logic              any_free,
  input  logic              free_en,
  input  logic [HW-1:0]     free_idx
);
  import xif_pkg::*;

  logic [NUM_HANDLES-1:0] used;
  logic [IFW-1:0]         ifx  [NUM_HANDLES];
  logic [ASID_W-1:0]      own  [NUM_HANDLES];
  int unsigned            pick;

  assign pick      = lowest_free(64'(used), NUM_HANDLES);
  assign alloc_idx = HW'(pick);
  assign any_free  = (pick != 0);

  assign rd_valid = used[rd_idx];
  assign rd_if    = ifx[rd_idx];
  assign rd_asid  = own[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      used <= '0;
    end else begin
      if (alloc_en) begin
        used[alloc_idx] <= 1'b1;
        ifx[alloc_idx]  <= alloc_if;
        own[alloc_idx]  <= alloc_asid;
      end
      if (free_en) used[free_idx] <= 1'b0;
    end
  end

  AST_ALLOC_WAS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> (!used[alloc_idx] && alloc_idx != '0)); // R1
  AST_SLOT0_UNUSED: assert property (@(posedge clk) disable iff (!rst_n)
    !used[0]); // R1
  AST_FREE_WAS_USED: assert property (@(posedge clk) disable iff (!rst_n)
    free_en |-> used[free_idx]); // R8

endmodule

// File: rtl/xif_dispatch.sv
module xif_dispatch #(
  parameter int NUM_IF      = 3,
  parameter int ID_W        = 20,
  parameter int NCTL        = 8,
  parameter int NUM_HANDLES = 16,
  parameter int ASID_W      = 8,
  parameter int XLEN        = 32,
  parameter int AUX_W       = 12,
  parameter logic [NUM_IF*ID_W-1:0] IF_IDS      = {20'hFEDCB, 20'h01234, 20'h0ABCD},
  parameter logic [NUM_IF*NCTL-1:0] IF_FN_MASK  = {8'hFF, 8'b1000_0001, 8'b0000_0011},
  parameter logic [NUM_IF-1:0]      IF_SHUTDOWN = 3'b101,
  localparam int HW    = $clog2(NUM_HANDLES),
  localparam int IFW   = (NUM_IF > 1) ? $clog2(NUM_IF) : 1,
  localparam int FNW   = $clog2(NCTL),
  localparam int ARG_W = (ID_W > AUX_W + HW) ? ID_W : AUX_W + HW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [FNW-1:0]    req_fn,
  input  logic [ARG_W-1:0]  req_arg,
  input  logic [ASID_W-1:0] req_asid,
  output logic              dev_valid,
  input  logic              dev_ready,
  output logic              dev_shutdown,
  output logic [IFW-1:0]    dev_if,
  output logic [FNW-1:0]    dev_fn,
  output logic [HW-1:0]     dev_handle,
  output logic [AUX_W-1:0]  dev_aux,
  input  logic              dev_rsp_valid,
  input  logic [XLEN-1:0]   dev_rsp_status,
  output logic              done_valid,
  output logic [2:0]        done_code,
  output logic [XLEN-1:0]   done_value
);
  import xif_pkg::*;

  typedef enum logic [1:0] {ST_IDLE, ST_DREQ, ST_DRSP} st_e;
  st_e state;

  // Named internal events
  logic              accept, is_open, is_close, is_ctl, owned;
  logic              open_miss, open_full, open_ok;
  logic              close_bad, close_fwd, close_now;
  logic              ctl_noif, ctl_noinsn, ctl_fwd, forward;
  logic              rsp_done, tbl_free;
  logic [HW-1:0]     req_handle, free_idx, alloc_idx;
  logic              rd_valid, any_free, id_hit, sel_shut;
  logic [IFW-1:0]    rd_if, id_idx;
  logic [ASID_W-1:0] rd_asid;
  logic [NCTL-1:0]   sel_mask;
  logic [2:0]        imm_code;
  logic [XLEN-1:0]   imm_value;

  assign req_ready  = (state == ST_IDLE);
  assign dev_valid  = (state == ST_DREQ);
  assign accept     = req_valid && req_ready;
  assign req_handle = req_arg[AUX_W +: HW];

  xif_handle_tbl #(.NUM_HANDLES(NUM_HANDLES), .IFW(IFW), .ASID_W(ASID_W), .HW(HW)) u_tbl (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(req_handle), .rd_valid(rd_valid), .rd_if(rd_if), .rd_asid(rd_asid),
    .alloc_en(accept && open_ok), .alloc_if(id_idx), .alloc_asid(req_asid),
    .alloc_idx(alloc_idx), .any_free(any_free),
    .free_en(tbl_free), .free_idx(free_idx)
  );

  xif_iface_map #(.NUM_IF(NUM_IF), .ID_W(ID_W), .NCTL(NCTL), .IFW(IFW),
                  .IF_IDS(IF_IDS), .IF_FN_MASK(IF_FN_MASK), .IF_SHUTDOWN(IF_SHUTDOWN)) u_map (
    .id_q(req_arg[ID_W-1:0]), .id_hit(id_hit), .id_idx(id_idx),
    .sel(rd_if), .sel_mask(sel_mask), .sel_shut(sel_shut)
  );

  // Request classification
  assign is_open  = (req_op == OP_OPEN);
  assign is_close = (req_op == OP_CLOSE);
  assign is_ctl   = (req_op == OP_CTL);
  assign owned    = rd_valid && (rd_asid == req_asid);

  assign open_miss  = is_open && !id_hit;
  assign open_full  = is_open && id_hit && !any_free;
  assign open_ok    = is_open && id_hit && any_free;
  assign close_bad  = is_close && !owned;
  assign close_fwd  = is_close && owned && sel_shut;
  assign close_now  = is_close && owned && !sel_shut;
  assign ctl_noif   = is_ctl && !owned;
  assign ctl_noinsn = is_ctl && owned && !sel_mask[req_fn];
  assign ctl_fwd    = is_ctl && owned && sel_mask[req_fn];
  assign forward    = close_fwd || ctl_fwd;

  assign rsp_done = (state == ST_DRSP) && dev_rsp_valid;
  assign tbl_free = (accept && close_now) ||
                    (rsp_done && dev_shutdown && dev_rsp_status == '0);
  assign free_idx = accept ? req_handle : dev_handle;

  always_comb begin
    imm_code  = RES_OK;
    imm_value = '0;
    if (open_miss || ctl_noif)  imm_code = RES_NOIF;
    else if (open_full)         imm_code = RES_FULL;
    else if (ctl_noinsn)        imm_code = RES_NOINSN;
    else if (close_bad) begin
      imm_code  = RES_CLOSE_ERR;
      imm_value = '1;
    end else if (open_ok)       imm_value = XLEN'(alloc_idx);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      done_valid   <= 1'b0;
      done_code    <= '0;
      done_value   <= '0;
      dev_shutdown <= 1'b0;
      dev_if       <= '0;
      dev_fn       <= '0;
      dev_handle   <= '0;
      dev_aux      <= '0;
    end else begin
      done_valid <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          if (forward) begin
            state        <= ST_DREQ;
            dev_shutdown <= is_close;
            dev_if       <= rd_if;
            dev_fn       <= req_fn;
            dev_handle   <= req_handle;
            dev_aux      <= req_arg[AUX_W-1:0];
          end else begin
            done_valid <= 1'b1;
            done_code  <= imm_code;
            done_value <= imm_value;
          end
        end
        ST_DREQ: if (dev_ready) state <= ST_DRSP;
        ST_DRSP: if (dev_rsp_valid) begin
          state      <= ST_IDLE;
          done_valid <= 1'b1;
          done_value <= dev_rsp_status;
          done_code  <= (dev_shutdown && dev_rsp_status != '0) ? RES_CLOSE_ERR : RES_OK;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_DEV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_valid && !dev_ready) |=> (dev_valid && $stable(dev_handle) && $stable(dev_fn) && $stable(dev_aux))); // R10
  AST_BUSY_WHILE_DEV: assert property (@(posedge clk) disable iff (!rst_n)
    dev_valid |-> !req_ready); // R10
  AST_NOINSN_NO_DEV: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && ctl_noinsn) |=> (!dev_valid && done_valid && done_code == RES_NOINSN)); // R6
  AST_NOIF_NO_DEV: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && ctl_noif) |=> (!dev_valid && done_code == RES_NOIF)); // R5
  AST_FULL_REPORTED: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && open_full) |=> (done_valid && done_code == RES_FULL)); // R3
  AST_FREE_REPORTS_OK: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_free |=> (done_valid && done_code == RES_OK && done_value == '0)); // R8

endmodule

// File: tb/tb_xif_dispatch.sv
module tb_xif_dispatch;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = '0;
  logic [2:0]  req_fn = '0;
  logic [19:0] req_arg = '0;
  logic [7:0]  req_asid = '0;
  logic        dev_valid;
  logic        dev_ready = 1'b0;
  logic        dev_shutdown;
  logic [1:0]  dev_if;
  logic [2:0]  dev_fn;
  logic [3:0]  dev_handle;
  logic [11:0] dev_aux;
  logic        dev_rsp_valid = 1'b0;
  logic [31:0] dev_rsp_status = '0;
  logic        done_valid;
  logic [2:0]  done_code;
  logic [31:0] done_value;

  always #10 clk = ~clk; // 50 MHz

  xif_dispatch dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op), .req_fn(req_fn),
    .req_arg(req_arg), .req_asid(req_asid),
    .dev_valid(dev_valid), .dev_ready(dev_ready), .dev_shutdown(dev_shutdown),
    .dev_if(dev_if), .dev_fn(dev_fn), .dev_handle(dev_handle), .dev_aux(dev_aux),
    .dev_rsp_valid(dev_rsp_valid), .dev_rsp_status(dev_rsp_status),
    .done_valid(done_valid), .done_code(done_code), .done_value(done_value)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Device model, entirely on falling edges
  logic [31:0] next_status = '0;
  int          dev_count = 0;
  int          dphase = 0;
  logic        cap_shut;
  logic [1:0]  cap_if;
  logic [2:0]  cap_fn;
  logic [3:0]  cap_handle;
  logic [11:0] cap_aux;

  always @(negedge clk) begin
    case (dphase)
      0: if (dev_valid) begin
        dev_ready  <= 1'b1;
        cap_shut   <= dev_shutdown;
        cap_if     <= dev_if;
        cap_fn     <= dev_fn;
        cap_handle <= dev_handle;
        cap_aux    <= dev_aux;
        dev_count  <= dev_count + 1;
        dphase     <= 1;
      end
      1: begin
        dev_ready      <= 1'b0;
        dev_rsp_valid  <= 1'b1;
        dev_rsp_status <= next_status;
        dphase         <= 2;
      end
      default: begin
        dev_rsp_valid <= 1'b0;
        dphase        <= 0;
      end
    endcase
  end

  logic [2:0]  got_code;
  logic [31:0] got_val;
  int          got_lat;
  logic        first_ready;

  task automatic run_req(input logic [1:0] op, input logic [2:0] fn, input logic [19:0] arg,
                         input logic [7:0] asid, input logic [31:0] dstat);
    next_status = dstat;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_fn = fn; req_arg = arg; req_asid = asid;
    @(negedge clk);
    req_valid = 1'b0;
    got_lat = 99; got_code = '1; got_val = '0;
    first_ready = req_ready;
    for (int k = 1; k <= 30; k++) begin
      if (k > 1) @(negedge clk);
      if (done_valid) begin
        got_lat = k; got_code = done_code; got_val = done_value;
        break;
      end
    end
  endtask

  typedef struct packed {
    logic [3:0]  rq;
    logic [1:0]  op;
    logic [2:0]  fn;
    logic [19:0] arg;
    logic [7:0]  asid;
    logic [31:0] dstat;
    logic [2:0]  code;
    logic [31:0] val;
    logic        dev;
    logic [1:0]  dif;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{4'd1, 2'd0, 3'd0, 20'h0ABCD, 8'd5, 32'h0,    3'd0, 32'h1,        1'b0, 2'd0}, // R1 open -> 1
    '{4'd1, 2'd0, 3'd0, 20'h01234, 8'd5, 32'h0,    3'd0, 32'h2,        1'b0, 2'd0}, // R1 open -> 2
    '{4'd2, 2'd0, 3'd0, 20'h55555, 8'd5, 32'h0,    3'd1, 32'h0,        1'b0, 2'd0}, // R2 unknown id
    '{4'd2, 2'd0, 3'd0, 20'hFEDCB, 8'd7, 32'h0,    3'd0, 32'h3,        1'b0, 2'd0}, // R2 nothing taken -> 3
    '{4'd4, 2'd2, 3'd1, 20'h01ABC, 8'd5, 32'h77,   3'd0, 32'h77,       1'b1, 2'd0}, // R4 forward
    '{4'd6, 2'd2, 3'd2, 20'h01000, 8'd5, 32'h0,    3'd2, 32'h0,        1'b0, 2'd0}, // R6 fn not in mask
    '{4'd5, 2'd2, 3'd0, 20'h01000, 8'd6, 32'h0,    3'd1, 32'h0,        1'b0, 2'd0}, // R5 other asid
    '{4'd5, 2'd2, 3'd0, 20'h09000, 8'd5, 32'h0,    3'd1, 32'h0,        1'b0, 2'd0}, // R5 free handle
    '{4'd4, 2'd2, 3'd7, 20'h02005, 8'd5, 32'h1,    3'd0, 32'h1,        1'b1, 2'd1}, // R4 other iface
    '{4'd7, 2'd1, 3'd0, 20'h01000, 8'd6, 32'h0,    3'd4, 32'hFFFFFFFF, 1'b0, 2'd0}, // R7 other asid
    '{4'd7, 2'd1, 3'd0, 20'h09000, 8'd5, 32'h0,    3'd4, 32'hFFFFFFFF, 1'b0, 2'd0}, // R7 free handle
    '{4'd8, 2'd1, 3'd0, 20'h01000, 8'd5, 32'h3,    3'd4, 32'h3,        1'b1, 2'd0}, // R8 shutdown refuses
    '{4'd8, 2'd2, 3'd0, 20'h01000, 8'd5, 32'h10,   3'd0, 32'h10,       1'b1, 2'd0}, // R8 still open
    '{4'd8, 2'd1, 3'd0, 20'h01000, 8'd5, 32'h0,    3'd0, 32'h0,        1'b1, 2'd0}, // R8 shutdown ok
    '{4'd8, 2'd2, 3'd0, 20'h01000, 8'd5, 32'h0,    3'd1, 32'h0,        1'b0, 2'd0}, // R8 now freed
    '{4'd9, 2'd1, 3'd0, 20'h02000, 8'd5, 32'h0,    3'd0, 32'h0,        1'b0, 2'd0}, // R9 no shutdown
    '{4'd9, 2'd2, 3'd0, 20'h02000, 8'd5, 32'h0,    3'd1, 32'h0,        1'b0, 2'd0}, // R9 freed
    '{4'd1, 2'd0, 3'd0, 20'h01234, 8'd9, 32'h0,    3'd0, 32'h1,        1'b0, 2'd0}, // R1 lowest free reused
    '{4'd1, 2'd2, 3'd0, 20'h00000, 8'd5, 32'h0,    3'd1, 32'h0,        1'b0, 2'd0}, // R1 handle 0 never live
    '{4'd4, 2'd2, 3'd5, 20'h03123, 8'd7, 32'hDEAD, 3'd0, 32'hDEAD,     1'b1, 2'd2}  // R4 iface 2
  };

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int dc0;
    string t;
    repeat (3) @(negedge clk);
    // reset state
    chk("reset req_ready", 32'(req_ready), 32'h1);
    chk("reset dev_valid", 32'(dev_valid), 32'h0);
    chk("reset done_valid", 32'(done_valid), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      dc0 = dev_count;
      run_req(VECS[i].op, VECS[i].fn, VECS[i].arg, VECS[i].asid, VECS[i].dstat);
      t = $sformatf("R%0d vec%0d", VECS[i].rq, i);
      chk({t, " code"}, 32'(got_code), 32'(VECS[i].code));
      chk({t, " value"}, got_val, VECS[i].val);
      chk({t, " device requests"}, 32'(dev_count - dc0), 32'(VECS[i].dev));
      chk({t, " R10 latency"}, 32'(got_lat), VECS[i].dev ? 32'd3 : 32'd1);
      if (VECS[i].dev) begin
        chk({t, " R10 busy"}, 32'(first_ready), 32'h0);
        chk({t, " dev_shutdown"}, 32'(cap_shut), 32'(VECS[i].op == 2'd1));
        chk({t, " dev_if"}, 32'(cap_if), 32'(VECS[i].dif));
        chk({t, " dev_handle"}, 32'(cap_handle), 32'(VECS[i].arg[15:12]));
        chk({t, " dev_aux"}, 32'(cap_aux), 32'(VECS[i].arg[11:0]));
        if (VECS[i].op == 2'd2) chk({t, " dev_fn"}, 32'(cap_fn), 32'(VECS[i].fn));
      end
    end

    // R1 / R3: handles 1 and 3 live; fill the rest in lowest-first order
    for (int k = 0; k < 13; k++) begin
      run_req(2'd0, 3'd0, 20'h0ABCD, 8'd1, 32'h0);
      chk("R1 fill code", 32'(got_code), 32'h0);
      chk("R1 fill handle", got_val, (k == 0) ? 32'd2 : 32'(k + 3));
    end
    run_req(2'd0, 3'd0, 20'h0ABCD, 8'd1, 32'h0);
    chk("R3 full code", 32'(got_code), 32'h3);
    chk("R3 full value", got_val, 32'h0);
    run_req(2'd0, 3'd0, 20'h00000, 8'd1, 32'h0);
    chk("R2 unknown while full", 32'(got_code), 32'h1);
    dc0 = dev_count;
    run_req(2'd1, 3'd0, 20'h03000, 8'd7, 32'h0);
    chk("R8 close h3 code", 32'(got_code), 32'h0);
    chk("R8 close h3 forwarded", 32'(dev_count - dc0), 32'h1);
    run_req(2'd0, 3'd0, 20'hFEDCB, 8'd2, 32'h0);
    chk("R1 reopen after full", got_val, 32'h3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule